// File: doc/BRIEF.md
# Dual-Clock FIFO with Strap-Selected Offset Loading

This block is a first-in first-out buffer for 9-bit words, with a write port and a read port that each run on their own clock. A word is stored only when both write-enable inputs allow it. A word is taken only when both read-enable inputs allow it. The write side drives the full and almost-full flags. The read side drives the empty and almost-empty flags. Each side builds its flags from its own pointer and from the other side's pointer. That pointer crosses between the clocks in Gray code through a two-stage synchronizer.

The second write-enable pin has two possible roles, and the level it holds while reset is asserted picks the role until the next reset. If the pin is high during reset, it is a plain second enable. If it is low during reset, it becomes a strobe for loading the thresholds. In that role, a cycle with the primary write enable high and the pin low does not write data. Instead it stores the data bus into the almost-empty threshold or the almost-full threshold, taking them in turn. A cycle with the primary write enable high and the pin high is then an ordinary write.

The read data sits in a register. A separate enable output stands in for a three-state driver and follows the output-enable input.

Top module: `strap_cfg_fifo`

## Requirements
- R1: While `rst` is high on a clock edge, `empty` and `almost_empty` become 1, `full` and `almost_full` become 0, and `rd_data` becomes 0. All of these hold once `rst` falls.
- R2: In enable mode (`wr_en_b_ld` high during reset), a word is stored only on a write-clock edge where `wr_en_a` and `wr_en_b_ld` are both 1 and `full` is 0. If either enable is 0 alone, nothing is stored.
- R3: A word is read only on a read-clock edge where `rd_en_a` and `rd_en_b` are both 1 and `empty` is 0. `empty` rises only after such a read.
- R4: In load mode (`wr_en_b_ld` low during reset), an edge with `wr_en_a`=1 and `wr_en_b_ld`=0 stores `wr_data[AW:0]` into a threshold and puts nothing into the FIFO. The loads go in turn: almost-empty threshold first, then almost-full threshold, then almost-empty again. A new reset restores both thresholds to their parameter defaults.
- R5: In load mode, an edge with `wr_en_a`=1 and `wr_en_b_ld`=1 and `full`=0 stores a data word.
- R6: Suppose a word is written into an empty FIFO on write edge k, and the clocks share one phase. Then `empty` falls after edge k+3, and `rd_data` shows the word after the first read edge that follows, which is k+4 when the read enables are held.
- R7: Words are read out in the order they were written, with their values unchanged.
- R8: `full` is 1 exactly when DEPTH (default 16) words are stored. A write while full is ignored, and `full` rises only after a write attempt.
- R9: `almost_empty` is 1 when the occupancy seen by the read side is at or below the almost-empty threshold. The default threshold is 7.
- R10: `almost_full` is 1 when the free space seen by the write side is at or below the almost-full threshold. The default threshold is 7.
- R11: `rd_data_oe` equals `out_en` in the same cycle, and `out_en` has no effect on `rd_data`.
- R12: `rd_data` changes only on a read edge that takes a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains; also samples the strap |
| wr_en_a | input | 1 | Primary write enable |
| wr_en_b_ld | input | 1 | Second write enable, or load strobe (active low) in load mode |
| wr_data | input | DW (9) | Write data, and threshold value during a load |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| out_en | input | 1 | Output enable |
| rd_data | output | DW (9) | Registered read data |
| rd_data_oe | output | 1 | Drive enable for the read data, modelling three-state |
| empty | output | 1 | No word available to read |
| almost_empty | output | 1 | Occupancy at or below the almost-empty threshold |
| full | output | 1 | No space to write |
| almost_full | output | 1 | Free space at or below the almost-full threshold |

## Verification
Some rules are checked on every clock edge. An empty FIFO always also reports almost-empty, and a full FIFO always also reports almost-full. `full` can rise only after a write attempt, and `empty` can rise only after a double-enabled read. The read data holds still whenever no read is taken. Other behaviour needs the bench's scenarios to show it. This covers the strap decision taken at reset, the order in which loads fill the two thresholds, the exact four-edge first-word latency, the order of the data, and the rule that stray single enables and load strobes never add words.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // Role of the dual-purpose write pin, latched while reset is high
  typedef enum logic {
    PIN_DUAL_ENABLE = 1'b0,
    PIN_LOAD_STROBE = 1'b1
  } pin_role_e;

  // Which threshold the next load strobe writes
  typedef enum logic {
    TGT_EMPTY_SIDE = 1'b0,
    TGT_FULL_SIDE  = 1'b1
  } load_tgt_e;
endpackage

// File: rtl/sfifo_sync.sv
module sfifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sfifo_ram.sv
module sfifo_ram #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sfifo_wr_side.sv
module sfifo_wr_side
  import sfifo_pkg::*;
#(
  parameter int AW     = 4,
  parameter int AE_DEF = 7,
  parameter int AF_DEF = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_a,
  input  logic          en_b_ld,
  input  logic [AW:0]   ld_val,
  input  logic [AW:0]   rgray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          almost_full,
  output logic [AW:0]   ae_thr
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(1 << AW);

  pin_role_e     role;
  load_tgt_e     tgt;
  logic [PW-1:0] wbin, wbin_nxt, rbin_s, occ_nxt, free_nxt, af_thr;
  logic          ld_fire;

  assign we      = en_a && en_b_ld && !full;
  assign ld_fire = (role == PIN_LOAD_STROBE) && en_a && !en_b_ld;
  assign waddr   = wbin[AW-1:0];

  always_comb begin
    rbin_s[PW-1] = rgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
    wbin_nxt = wbin + {{(PW-1){1'b0}}, we};
    occ_nxt  = wbin_nxt - rbin_s;
    free_nxt = DEPTH_V - occ_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      role        <= en_b_ld ? PIN_DUAL_ENABLE : PIN_LOAD_STROBE;
      tgt         <= TGT_EMPTY_SIDE;
      wbin        <= '0;
      wgray       <= '0;
      full        <= 1'b0;
      almost_full <= 1'b0;
      ae_thr      <= PW'(AE_DEF);
      af_thr      <= PW'(AF_DEF);
    end else begin
      wbin        <= wbin_nxt;
      wgray       <= wbin_nxt ^ (wbin_nxt >> 1);
      full        <= (occ_nxt == DEPTH_V);
      almost_full <= (free_nxt <= af_thr);
      if (ld_fire) begin
        if (tgt == TGT_EMPTY_SIDE) ae_thr <= ld_val;
        else                       af_thr <= ld_val;
        tgt <= (tgt == TGT_EMPTY_SIDE) ? TGT_FULL_SIDE : TGT_EMPTY_SIDE;
      end
    end
  end
endmodule

// File: rtl/sfifo_rd_side.sv
module sfifo_rd_side #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_a,
  input  logic          en_b,
  input  logic [AW:0]   wgray_s,
  input  logic [AW:0]   ae_thr,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          empty,
  output logic          almost_empty
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin, rbin_nxt, wbin_s, occ_nxt;

  assign re    = en_a && en_b && !empty;
  assign raddr = rbin[AW-1:0];

  always_comb begin
    wbin_s[PW-1] = wgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
    rbin_nxt = rbin + {{(PW-1){1'b0}}, re};
    occ_nxt  = wbin_s - rbin_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin         <= '0;
      rgray        <= '0;
      empty        <= 1'b1;
      almost_empty <= 1'b1;
    end else begin
      rbin         <= rbin_nxt;
      rgray        <= rbin_nxt ^ (rbin_nxt >> 1);
      empty        <= (occ_nxt == '0);
      almost_empty <= (occ_nxt <= ae_thr);
    end
  end
endmodule

// File: rtl/strap_cfg_fifo.sv
module strap_cfg_fifo #(
  parameter int DW     = 9,
  parameter int AW     = 4,
  parameter int AE_DEF = 7,
  parameter int AF_DEF = 7
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst,
  input  logic          wr_en_a,
  input  logic          wr_en_b_ld,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en_a,
  input  logic          rd_en_b,
  input  logic          out_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_data_oe,
  output logic          empty,
  output logic          almost_empty,
  output logic          full,
  output logic          almost_full
);
  localparam int PW = AW + 1;

  logic          we, re;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s, ae_thr;

  sfifo_wr_side #(.AW(AW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_wr (
    .clk(wr_clk), .rst(rst), .en_a(wr_en_a), .en_b_ld(wr_en_b_ld),
    .ld_val(wr_data[PW-1:0]), .rgray_s(rgray_s), .we(we), .waddr(waddr),
    .wgray(wgray), .full(full), .almost_full(almost_full), .ae_thr(ae_thr)
  );

  sfifo_sync #(.W(PW), .STAGES(2)) u_w2r (
    .clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_s)
  );

  sfifo_sync #(.W(PW), .STAGES(2)) u_r2w (
    .clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_s)
  );

  sfifo_rd_side #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst(rst), .en_a(rd_en_a), .en_b(rd_en_b),
    .wgray_s(wgray_s), .ae_thr(ae_thr), .re(re), .raddr(raddr),
    .rgray(rgray), .empty(empty), .almost_empty(almost_empty)
  );

  sfifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rd_clk(rd_clk), .rd_rst(rst), .re(re), .raddr(raddr), .rdata(rd_data)
  );

  assign rd_data_oe = out_en;
endmodule

// File: rtl/sfifo_checker.sv
module sfifo_checker #(
  parameter int DW = 9
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst,
  input logic          wr_en_a,
  input logic          wr_en_b_ld,
  input logic          rd_en_a,
  input logic          rd_en_b,
  input logic [DW-1:0] rd_data,
  input logic          empty,
  input logic          almost_empty,
  input logic          full,
  input logic          almost_full
);
  p_ae_covers_empty_r9: assert property (@(posedge rd_clk) disable iff (rst)
    empty |-> almost_empty);

  p_af_covers_full_r10: assert property (@(posedge wr_clk) disable iff (rst)
    full |-> almost_full);

  p_full_after_write_r8: assert property (@(posedge wr_clk) disable iff (rst)
    $rose(full) |-> $past(wr_en_a && wr_en_b_ld));

  p_empty_after_read_r3: assert property (@(posedge rd_clk) disable iff (rst)
    $rose(empty) |-> $past(rd_en_a && rd_en_b));

  p_data_holds_r12: assert property (@(posedge rd_clk) disable iff (rst)
    !(rd_en_a && rd_en_b && !empty) |=> $stable(rd_data));
endmodule

bind strap_cfg_fifo sfifo_checker #(.DW(DW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en_a(wr_en_a),
  .wr_en_b_ld(wr_en_b_ld), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
  .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty),
  .full(full), .almost_full(almost_full)
);

// File: tb/tb_strap_cfg_fifo.sv
module tb_strap_cfg_fifo;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en_a = 1'b0, wr_en_b_ld = 1'b1, rd_en_a = 1'b0, rd_en_b = 1'b0;
  logic       out_en = 1'b1;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic       rd_data_oe, empty, almost_empty, full, almost_full;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  localparam logic [8:0] VEC [8] = '{9'h0A1, 9'h1FF, 9'h000, 9'h155,
                                     9'h0AA, 9'h13C, 9'h081, 9'h17E};

  always #5 clk = ~clk;

  strap_cfg_fifo dut (
    .wr_clk(clk), .rd_clk(clk), .rst(rst), .wr_en_a(wr_en_a),
    .wr_en_b_ld(wr_en_b_ld), .wr_data(wr_data), .rd_en_a(rd_en_a),
    .rd_en_b(rd_en_b), .out_en(out_en), .rd_data(rd_data),
    .rd_data_oe(rd_data_oe), .empty(empty), .almost_empty(almost_empty),
    .full(full), .almost_full(almost_full)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_with(input logic pin);
    rst = 1'b1; wr_en_b_ld = pin; wr_en_a = 1'b0; rd_en_a = 1'b0; rd_en_b = 1'b0;
    tick(3);
    rst = 1'b0; wr_en_b_ld = 1'b0;
  endtask

  task automatic push(input logic [8:0] d);
    wr_en_a = 1'b1; wr_en_b_ld = 1'b1; wr_data = d;
    tick(1);
    wr_en_a = 1'b0; wr_en_b_ld = 1'b0;
  endtask

  task automatic load(input logic [8:0] v);
    wr_en_a = 1'b1; wr_en_b_ld = 1'b0; wr_data = v;
    tick(1);
    wr_en_a = 1'b0;
  endtask

  task automatic pop_check(input logic [8:0] exp, input string req);
    rd_en_a = 1'b1; rd_en_b = 1'b1;
    tick(1);
    rd_en_a = 1'b0; rd_en_b = 1'b0;
    chk(req, rd_data, exp);
  endtask

  task automatic check_reset_state(input string req);
    chk({req, " empty"}, empty, 1);
    chk({req, " almost_empty"}, almost_empty, 1);
    chk({req, " full"}, full, 0);
    chk({req, " almost_full"}, almost_full, 0);
    chk({req, " rd_data"}, rd_data, 0);
  endtask

  initial begin
    tick(1);
    reset_with(1'b1);
    check_reset_state("R1");
    chk("R11 oe on", rd_data_oe, 1);
    out_en = 1'b0; #1;
    chk("R11 oe off", rd_data_oe, 0);
    chk("R11 data kept", rd_data, 0);
    out_en = 1'b1;

    // R6: first-word latency at the empty boundary
    wr_en_a = 1'b1; wr_en_b_ld = 1'b1; wr_data = 9'h1A5; rd_en_a = 1'b1; rd_en_b = 1'b1;
    tick(1);
    wr_en_a = 1'b0; wr_en_b_ld = 1'b0;
    chk("R6 empty k", empty, 1);
    tick(1); chk("R6 empty k+1", empty, 1);
    tick(1); chk("R6 empty k+2", empty, 1);
    tick(1); chk("R6 empty k+3", empty, 0);
    chk("R6 data k+3", rd_data, 0);
    tick(1); chk("R6 data k+4", rd_data, 9'h1A5);
    chk("R6 empty after read", empty, 1);
    rd_en_a = 1'b0; rd_en_b = 1'b0;

    // R2: single write enables store nothing
    wr_en_a = 1'b1; wr_en_b_ld = 1'b0; wr_data = 9'h011; tick(1);
    wr_en_a = 1'b0; wr_en_b_ld = 1'b1; wr_data = 9'h022; tick(1);
    wr_en_b_ld = 1'b0;
    tick(5);
    chk("R2 single enable ignored", empty, 1);
    push(9'h033);
    tick(4);
    chk("R2 double enable stores", empty, 0);

    // R3: single read enables take nothing
    rd_en_a = 1'b1; tick(2); rd_en_a = 1'b0;
    rd_en_b = 1'b1; tick(2); rd_en_b = 1'b0;
    chk("R3 single read data", rd_data, 9'h1A5);
    chk("R3 single read empty", empty, 0);
    pop_check(9'h033, "R3");
    chk("R3 empty after last", empty, 1);
    rd_en_a = 1'b1; rd_en_b = 1'b1; tick(2); rd_en_a = 1'b0; rd_en_b = 1'b0;
    chk("R3 read when empty", rd_data, 9'h033);

    // R9 threshold boundary, then R7 ordering from the vector table
    for (int i = 0; i < 7; i++) push(VEC[i]);
    tick(4);
    chk("R9 occ 7 almost_empty", almost_empty, 1);
    push(VEC[7]);
    tick(4);
    chk("R9 occ 8 almost_empty", almost_empty, 0);
    for (int i = 0; i < 8; i++) begin
      pop_check(VEC[i], "R7");
      if (i == 0) chk("R9 occ 7 after read", almost_empty, 1);
    end
    chk("R7 empty after table", empty, 1);

    // R8 / R10: fill to full
    for (int i = 0; i < 16; i++) begin
      push(9'h100 + 9'(i));
      chk("R10 almost_full", almost_full, (i >= 8) ? 1 : 0);
      chk("R8 full", full, (i == 15) ? 1 : 0);
    end
    push(9'h0EE);
    chk("R8 full held", full, 1);
    tick(4);
    for (int i = 0; i < 16; i++) pop_check(9'h100 + 9'(i), "R8");
    chk("R8 overflow word dropped", empty, 1);
    tick(3);
    chk("R8 full cleared", full, 0);
    chk("R10 almost_full cleared", almost_full, 0);

    // R4 / R5: load mode
    reset_with(1'b0);
    check_reset_state("R1 load mode");
    load(9'd2);
    load(9'd3);
    tick(5);
    chk("R4 loads add no data", empty, 1);
    push(9'h0C1); push(9'h0C2); push(9'h0C3);
    tick(4);
    chk("R5 write in load mode", empty, 0);
    chk("R4 ae threshold 2", almost_empty, 0);
    for (int i = 0; i < 9; i++) push(9'h0D0 + 9'(i));
    chk("R4 af threshold 3 free 4", almost_full, 0);
    push(9'h0DF);
    chk("R4 af threshold 3 free 3", almost_full, 1);
    tick(4);
    pop_check(9'h0C1, "R5");
    load(9'd12);
    tick(3);
    chk("R4 third load to ae", almost_empty, 1);

    // Back to enable mode: reset restores defaults
    reset_with(1'b1);
    check_reset_state("R1 second reset");
    wr_en_a = 1'b1; wr_en_b_ld = 1'b0; wr_data = 9'd1; tick(1); wr_en_a = 1'b0;
    tick(5);
    chk("R2 no load in enable mode", empty, 1);
    for (int i = 0; i < 9; i++) push(9'h050 + 9'(i));
    chk("R10 default threshold restored", almost_full, 1);
    tick(4);
    chk("R4 default ae restored", almost_empty, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule